// File: doc/BRIEF.md
# Morton-Order Index Generator

This unit turns integer coordinates into one bit-interleaved element index, so that points close together in a 2D or 3D grid get nearby indices and tend to share a cache line. The index only selects a whole array element. The data stored at that element is never rearranged. A tiled 2D layout is also available. It interleaves the low coordinate bits in three-bit groups and keeps the high bits in plain order, which suits texture-style tile storage.

The unit can also step one axis of an index that is already interleaved. It adds or subtracts a step in that axis directly on the index, without taking the index apart. Before an ordinary add, the unit fills the bits of the other axes with ones, so the carry ripples across them. Before a subtract, it fills those bits with zeros, so the borrow ripples across them. The updated axis is then masked out and merged with the untouched bits. No reverse conversion exists, so a caller that needs the plain coordinates again must keep them. Each accepted request gives one result a single clock later.

Top module: `morton_addr_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `outValid` and `idxOut` to zero at the next rising edge.
- R2: `outValid` equals `inValid` from one clock earlier, and each result appears exactly one clock after its request. While no request is taken, `idxOut` holds its last value.
- R3: With `mode` 0 or 3 and `op` 0 or 3 (encode), `idxOut` bit 2i is `xIn[i]` and bit 2i+1 is `yIn[i]` for i = 0..15.
- R4: With `mode` 1 and `op` 0 or 3, bit 3i is `xIn[i]`, bit 3i+1 is `yIn[i]` and bit 3i+2 is `zIn[i]` for i = 0..9. `xIn` and `yIn` bits 15..10 are ignored. For every operation in `mode` 1, bits 31..30 of the result are zero.
- R5: With `mode` 2 (tiled), `op`, `dim`, `idxIn` and `stepIn` are ignored. The result, from bit 31 down, is `yIn[15:6]`, `xIn[15:6]`, `yIn[5:3]`, `xIn[5:3]`, `yIn[2:0]`, `xIn[2:0]`.
- R6: With `op` 1 (add) in `mode` 0/3 (2D) or 1 (3D), the axis picked by `dim` (0 = x, 1 = y, 2 = z) in `idxIn` becomes its old value plus `stepIn`. In 3D only `stepIn` bits 9..0 count. The bits of every other axis pass through unchanged.
- R7: With `op` 2 (subtract), the picked axis becomes its old value minus `stepIn`, and the bits of every other axis pass through unchanged.
- R8: Axis updates wrap modulo 2^16 in 2D and 2^10 in 3D. Adding 1 to an all-ones axis gives zero, and subtracting 1 from zero gives all ones. Neither disturbs any other bit.
- R9: An update whose `dim` names no axis of the mode (2 or 3 in 2D, 3 in 3D) returns `idxIn` unchanged. In 3D, bits 31..30 are still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| mode | input | 2 | 0/3 = 2D, 1 = 3D, 2 = tiled 2D |
| op | input | 2 | 0/3 = encode, 1 = add to axis, 2 = subtract from axis |
| dim | input | 2 | Axis to update: 0 = x, 1 = y, 2 = z |
| xIn | input | 16 | X coordinate |
| yIn | input | 16 | Y coordinate |
| zIn | input | 10 | Z coordinate (3D only) |
| idxIn | input | 32 | Interleaved index to update |
| stepIn | input | 16 | Step added to or subtracted from the axis |
| outValid | output | 1 | Result strobe |
| idxOut | output | 32 | Resulting index |

## Verification
The bench builds the unit with its default widths: 16 bits per axis in 2D, 10 bits per axis in 3D, and two three-bit tile groups. With these widths the 2D x axis ends at bit 30 and the 3D z axis ends at bit 29. As a result, a carry leaving the top of an axis has to cross the filler bits above it and drop off the word, and the two bits above a 3D index lie within reach. The wrap corners at all ones and at zero are driven on every axis of both modes, together with random updates and encodings that a per-bit reference model checks.

// File: rtl/morton_pkg.sv
package morton_pkg;

  typedef enum logic [1:0] {
    K_ENC2 = 2'd0,
    K_ENC3 = 2'd1,
    K_TILE = 2'd2,
    K_UPD  = 2'd3
  } kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    kind_e      kind;
    logic       subtract;
    logic       axes3;
    logic [2:0] laneSel;   // one-hot x/y/z, zero when dim names no axis
  } ctrl_t;

endpackage

// File: rtl/morton_ctrl.sv
module morton_ctrl
  import morton_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] mode,
  input  logic [1:0] op,
  input  logic [1:0] dim,
  output ctrl_t      strobe
);

  logic isUpd;

  always_comb begin
    isUpd = (op == 2'd1) || (op == 2'd2);
    strobe = '0;
    strobe.load = inValid;
    strobe.subtract = (op == 2'd2);
    case (mode)
      2'd2: strobe.kind = K_TILE;
      2'd1: begin
        strobe.axes3 = 1'b1;
        strobe.kind = isUpd ? K_UPD : K_ENC3;
        case (dim)
          2'd0: strobe.laneSel = 3'b001;
          2'd1: strobe.laneSel = 3'b010;
          2'd2: strobe.laneSel = 3'b100;
          default: strobe.laneSel = 3'b000;
        endcase
      end
      default: begin
        strobe.kind = isUpd ? K_UPD : K_ENC2;
        case (dim)
          2'd0: strobe.laneSel = 3'b001;
          2'd1: strobe.laneSel = 3'b010;
          default: strobe.laneSel = 3'b000;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/morton_dp.sv
module morton_dp
  import morton_pkg::*;
#(
  parameter int W2 = 16,
  parameter int W3 = 10,
  parameter int TILE_BITS = 3,
  parameter int TILE_GROUPS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           strobe,
  input  logic [W2-1:0]   xIn,
  input  logic [W2-1:0]   yIn,
  input  logic [W3-1:0]   zIn,
  input  logic [2*W2-1:0] idxIn,
  input  logic [W2-1:0]   stepIn,
  output logic            outValid,
  output logic [2*W2-1:0] idxOut
);

  localparam int IW = 2 * W2;
  localparam int N3 = 3 * W3;
  localparam int TL = TILE_BITS * TILE_GROUPS;

  logic [IW-1:0] enc2, enc3, encTile;
  logic [IW-1:0] lane2 [2];
  logic [IW-1:0] lane3 [3];
  logic [IW-1:0] spr2 [2];
  logic [IW-1:0] spr3 [3];
  logic [IW-1:0] laneM, laneS, validM, low3;
  logic [IW-1:0] sumV, diffV, rawV, updV, nxt;

  // plain 2D interleave
  genvar gi, gk;
  generate
    for (gi = 0; gi < W2; gi++) begin : g_enc2
      assign enc2[2*gi]   = xIn[gi];
      assign enc2[2*gi+1] = yIn[gi];
    end
    for (gi = 0; gi < W3; gi++) begin : g_enc3
      assign enc3[3*gi]   = xIn[gi];
      assign enc3[3*gi+1] = yIn[gi];
      assign enc3[3*gi+2] = zIn[gi];
    end
    if (N3 < IW) begin : g_enc3_pad
      assign enc3[IW-1:N3] = '0;
    end
    // grouped tile: low groups alternate x then y
    for (gi = 0; gi < TILE_GROUPS; gi++) begin : g_tgrp
      for (gk = 0; gk < TILE_BITS; gk++) begin : g_tbit
        assign encTile[gi*2*TILE_BITS + gk]             = xIn[gi*TILE_BITS + gk];
        assign encTile[gi*2*TILE_BITS + TILE_BITS + gk] = yIn[gi*TILE_BITS + gk];
      end
    end
    // high bits linear: x above the groups, y on top
    for (gi = 0; gi < W2 - TL; gi++) begin : g_thi
      assign encTile[2*TL + gi]            = xIn[TL + gi];
      assign encTile[2*TL + (W2-TL) + gi]  = yIn[TL + gi];
    end
  endgenerate

  // lane masks and step spreading per axis
  always_comb begin
    for (int d = 0; d < 2; d++) begin
      lane2[d] = '0;
      spr2[d]  = '0;
      for (int b = 0; b < IW; b++) lane2[d][b] = ((b % 2) == d);
      for (int i = 0; i < W2; i++) spr2[d][2*i+d] = stepIn[i];
    end
    for (int d = 0; d < 3; d++) begin
      lane3[d] = '0;
      spr3[d]  = '0;
      for (int b = 0; b < N3; b++) lane3[d][b] = ((b % 3) == d);
      for (int i = 0; i < W3; i++) spr3[d][3*i+d] = stepIn[i];
    end
    low3 = '0;
    for (int b = 0; b < N3; b++) low3[b] = 1'b1;
  end

  always_comb begin
    laneM  = '0;
    laneS  = '0;
    validM = '1;
    if (strobe.axes3) begin
      validM = low3;
      for (int d = 0; d < 3; d++) begin
        if (strobe.laneSel[d]) begin
          laneM = laneM | lane3[d];
          laneS = laneS | spr3[d];
        end
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (strobe.laneSel[d]) begin
          laneM = laneM | lane2[d];
          laneS = laneS | spr2[d];
        end
      end
    end
  end

  // fill other lanes with ones so carries ripple, zeros so borrows ripple
  always_comb begin
    sumV  = (idxIn | ~laneM) + laneS;
    diffV = (idxIn & laneM) - laneS;
    rawV  = strobe.subtract ? diffV : sumV;
    updV  = (rawV & laneM) | (idxIn & ~laneM & validM);
    case (strobe.kind)
      K_ENC3:  nxt = enc3;
      K_TILE:  nxt = encTile;
      K_UPD:   nxt = updV;
      default: nxt = enc2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      idxOut   <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) idxOut <= nxt;
    end
  end

endmodule

// File: rtl/morton_addr_unit.sv
module morton_addr_unit
  import morton_pkg::*;
#(
  parameter int W2 = 16,
  parameter int W3 = 10,
  parameter int TILE_BITS = 3,
  parameter int TILE_GROUPS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [1:0]      mode,
  input  logic [1:0]      op,
  input  logic [1:0]      dim,
  input  logic [W2-1:0]   xIn,
  input  logic [W2-1:0]   yIn,
  input  logic [W3-1:0]   zIn,
  input  logic [2*W2-1:0] idxIn,
  input  logic [W2-1:0]   stepIn,
  output logic            outValid,
  output logic [2*W2-1:0] idxOut
);

  ctrl_t strobe;

  morton_ctrl u_ctrl (
    .inValid (inValid),
    .mode    (mode),
    .op      (op),
    .dim     (dim),
    .strobe  (strobe)
  );

  morton_dp #(
    .W2          (W2),
    .W3          (W3),
    .TILE_BITS   (TILE_BITS),
    .TILE_GROUPS (TILE_GROUPS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .xIn      (xIn),
    .yIn      (yIn),
    .zIn      (zIn),
    .idxIn    (idxIn),
    .stepIn   (stepIn),
    .outValid (outValid),
    .idxOut   (idxOut)
  );

endmodule

// File: rtl/morton_chk.sv
module morton_chk #(
  parameter int W2 = 16,
  parameter int W3 = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic [1:0]      mode,
  input logic [1:0]      op,
  input logic [1:0]      dim,
  input logic [W2-1:0]   xIn,
  input logic [W2-1:0]   yIn,
  input logic [W3-1:0]   zIn,
  input logic [2*W2-1:0] idxIn,
  input logic [W2-1:0]   stepIn,
  input logic            outValid,
  input logic [2*W2-1:0] idxOut
);

  localparam int IW = 2 * W2;
  localparam logic [IW-1:0] ODD_BITS  = {W2{2'b10}};
  localparam logic [IW-1:0] EVEN_BITS = {W2{2'b01}};

  logic pastRst;
  always_ff @(posedge clk) pastRst <= rst;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    pastRst |-> (!outValid && idxOut == '0));

  // R2
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !pastRst |-> (outValid == $past(inValid)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pastRst && !$past(inValid)) |-> $stable(idxOut));

  // R4
  top3d_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(mode) == 2'd1) |-> (idxOut[IW-1:3*W3] == '0));

  // R5
  tile_low_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(mode) == 2'd2) |->
      (idxOut[2:0] == $past(xIn[2:0]) && idxOut[5:3] == $past(yIn[2:0])));

  // R6
  add_keep_y_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(mode == 2'd0 && op == 2'd1 && dim == 2'd0)) |->
      ((idxOut & ODD_BITS) == ($past(idxIn) & ODD_BITS)));

  // R7
  sub_keep_x_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(mode == 2'd0 && op == 2'd2 && dim == 2'd1)) |->
      ((idxOut & EVEN_BITS) == ($past(idxIn) & EVEN_BITS)));

endmodule

bind morton_addr_unit morton_chk #(.W2(W2), .W3(W3)) u_chk (.*);

// File: tb/morton_addr_unit_test.sv
module morton_addr_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  mode = '0, op = '0, dim = '0;
  logic [15:0] xIn = '0, yIn = '0, stepIn = '0;
  logic [9:0]  zIn = '0;
  logic [31:0] idxIn = '0;
  logic        outValid;
  logic [31:0] idxOut;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastExp = '0;

  always #5 clk = ~clk;

  morton_addr_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .mode(mode), .op(op), .dim(dim),
    .xIn(xIn), .yIn(yIn), .zIn(zIn), .idxIn(idxIn), .stepIn(stepIn),
    .outValid(outValid), .idxOut(idxOut)
  );

  // reference model, bit by bit
  function automatic logic [31:0] ref2(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      r[2*i] = x[i];
      r[2*i+1] = y[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] ref3(input logic [15:0] x, input logic [15:0] y,
                                       input logic [9:0] z);
    logic [31:0] r = '0;
    for (int i = 0; i < 10; i++) begin
      r[3*i] = x[i];
      r[3*i+1] = y[i];
      r[3*i+2] = z[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] refTile(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] r = '0;
    for (int i = 0; i < 3; i++) begin
      r[i] = x[i];
      r[3+i] = y[i];
      r[6+i] = x[3+i];
      r[9+i] = y[3+i];
    end
    r[21:12] = x[15:6];
    r[31:22] = y[15:6];
    return r;
  endfunction

  function automatic logic [31:0] refUpd(input int axes, input int d, input logic [31:0] idx,
                                         input logic [15:0] st, input logic sub);
    logic [31:0] r = idx;
    logic [15:0] f = '0;
    int n = (axes == 2) ? 16 : 10;
    if (axes == 3) r[31:30] = 2'b00;
    if (d >= axes) return r;
    for (int i = 0; i < n; i++) f[i] = idx[axes*i+d];
    f = sub ? (f - st) : (f + st);
    for (int i = 0; i < n; i++) r[axes*i+d] = f[i];
    return r;
  endfunction

  function automatic logic [31:0] expect_of(input logic [1:0] m, input logic [1:0] o,
      input logic [1:0] d, input logic [15:0] x, input logic [15:0] y, input logic [9:0] z,
      input logic [31:0] idx, input logic [15:0] st);
    logic isUpd = (o == 2'd1) || (o == 2'd2);
    if (m == 2'd2) return refTile(x, y);
    if (m == 2'd1) return isUpd ? refUpd(3, int'(d), idx, st, o == 2'd2) : ref3(x, y, z);
    return isUpd ? refUpd(2, int'(d), idx, st, o == 2'd2) : ref2(x, y);
  endfunction

  task automatic send(input logic [1:0] m, input logic [1:0] o, input logic [1:0] d,
                      input logic [15:0] x, input logic [15:0] y, input logic [9:0] z,
                      input logic [31:0] idx, input logic [15:0] st, input string tag);
    @(negedge clk);
    mode = m; op = o; dim = d; xIn = x; yIn = y; zIn = z; idxIn = idx; stepIn = st;
    inValid = 1'b1;
    lastExp = expect_of(m, o, d, x, y, z, idx, st);
    expQ.push_back(lastExp);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    mode = 2'($urandom); op = 2'($urandom); idxIn = $urandom;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: results arrive in request order
  always @(negedge clk) begin
    if (!rst && outValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R2: actual=outValid 1 expected=no result pending");
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (idxOut !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, idxOut, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid", {31'b0, outValid}, 32'd0);
    chk("R1 index", idxOut, 32'd0);

    // R3 fixed 2D patterns
    send(2'd0, 2'd0, 2'd0, 16'h0000, 16'h0000, 10'h0, '0, '0, "R3 zero");
    send(2'd0, 2'd0, 2'd0, 16'hFFFF, 16'h0000, 10'h0, '0, '0, "R3 x only");
    send(2'd0, 2'd0, 2'd0, 16'h0000, 16'hFFFF, 10'h0, '0, '0, "R3 y only");
    send(2'd3, 2'd3, 2'd0, 16'h1234, 16'hABCD, 10'h0, '0, '0, "R3 alt codes");
    idle();
    idle();
    // R2 hold after idle
    chk("R2 idle valid", {31'b0, outValid}, 32'd0);
    chk("R2 idle hold", idxOut, lastExp);
    chk("R3 0x5555", ref2(16'hFFFF, 16'h0), 32'h5555_5555);

    for (int k = 0; k < 20; k++)
      send(2'(k % 2 ? 3 : 0), 2'(k % 3 ? 0 : 3), 2'($urandom), 16'($urandom), 16'($urandom),
           10'($urandom), $urandom, 16'($urandom), "R3 random");

    // R4 3D encode, high x/y bits must be dropped
    send(2'd1, 2'd0, 2'd0, 16'h03FF, 16'h0000, 10'h000, '0, '0, "R4 x only");
    send(2'd1, 2'd0, 2'd0, 16'hFC00, 16'hFC00, 10'h000, '0, '0, "R4 upper ignored");
    for (int k = 0; k < 20; k++)
      send(2'd1, 2'(k % 2 ? 3 : 0), 2'($urandom), 16'($urandom), 16'($urandom), 10'($urandom),
           $urandom, 16'($urandom), "R4 random");
    idle();

    // R5 tiled
    send(2'd2, 2'd0, 2'd0, 16'h003F, 16'h0000, 10'h0, '0, '0, "R5 x low");
    send(2'd2, 2'd1, 2'd2, 16'h0000, 16'hFFC0, 10'h0, 32'hFFFF_FFFF, 16'h1, "R5 y high");
    for (int k = 0; k < 20; k++)
      send(2'd2, 2'($urandom), 2'($urandom), 16'($urandom), 16'($urandom), 10'($urandom),
           $urandom, 16'($urandom), "R5 random");
    idle();

    // R6 / R7 random updates on each axis
    for (int k = 0; k < 40; k++) begin
      send(2'd0, 2'd1, 2'(k % 2), 16'h0, 16'h0, 10'h0, $urandom, 16'($urandom), "R6 add 2D");
      send(2'd0, 2'd2, 2'(k % 2), 16'h0, 16'h0, 10'h0, $urandom, 16'($urandom), "R7 sub 2D");
      send(2'd1, 2'd1, 2'(k % 3), 16'h0, 16'h0, 10'h0, $urandom, 16'($urandom), "R6 add 3D");
      send(2'd1, 2'd2, 2'(k % 3), 16'h0, 16'h0, 10'h0, $urandom, 16'($urandom), "R7 sub 3D");
    end
    idle();

    // R8 wrap corners on every axis
    for (int d = 0; d < 2; d++) begin
      logic [31:0] full = (d == 0) ? ref2(16'hFFFF, 16'($urandom)) : ref2(16'($urandom), 16'hFFFF);
      logic [31:0] empty = (d == 0) ? ref2(16'h0, 16'($urandom)) : ref2(16'($urandom), 16'h0);
      send(2'd0, 2'd1, 2'(d), '0, '0, '0, full, 16'h0001, "R8 2D ones plus one");
      send(2'd0, 2'd2, 2'(d), '0, '0, '0, empty, 16'h0001, "R8 2D zero minus one");
      send(2'd0, 2'd1, 2'(d), '0, '0, '0, full, 16'hFFFF, "R8 2D ones plus max");
    end
    for (int d = 0; d < 3; d++) begin
      logic [31:0] full = ref3(d == 0 ? 16'h3FF : 16'($urandom), d == 1 ? 16'h3FF : 16'($urandom),
                               d == 2 ? 10'h3FF : 10'($urandom));
      logic [31:0] empty = ref3(d == 0 ? 16'h0 : 16'($urandom), d == 1 ? 16'h0 : 16'($urandom),
                                d == 2 ? 10'h0 : 10'($urandom));
      send(2'd1, 2'd1, 2'(d), '0, '0, '0, full | 32'hC000_0000, 16'h0001, "R8 3D ones plus one");
      send(2'd1, 2'd2, 2'(d), '0, '0, '0, empty, 16'h0001, "R8 3D zero minus one");
      send(2'd1, 2'd2, 2'(d), '0, '0, '0, empty, 16'hFC01, "R8 3D step high ignored");
    end
    chk("R8 2D corner model", refUpd(2, 0, 32'h5555_5555, 16'h1, 1'b0), 32'h0);
    chk("R8 3D corner model", refUpd(3, 2, 32'h0, 16'h1, 1'b1), 32'h2492_4924);
    idle();

    // R9 dim naming no axis
    send(2'd0, 2'd1, 2'd2, '0, '0, '0, 32'hDEAD_BEEF, 16'h0001, "R9 2D dim2");
    send(2'd0, 2'd2, 2'd3, '0, '0, '0, 32'h1357_9BDF, 16'h0003, "R9 2D dim3");
    send(2'd1, 2'd1, 2'd3, '0, '0, '0, 32'hFFFF_FFFF, 16'h0001, "R9 3D dim3");
    idle();
    idle();
    chk("R2 drained", expQ.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule